// File: doc/BRIEF.md
# Serial-Loaded 12-Bit DAC Control Core

This block is the digital side of a 12-bit voltage-output converter that a host loads over a three-wire serial link. The host lowers an active-low select, presents data on a data line, and the block samples that line on each rising serial clock edge. Each frame is 16 bits, sent most significant bit first. The first three bits are a command, the next twelve are a code, and the last is a filler bit. When the select line goes high, the block acts on the command. The code passes through two stages: a staging register, then the register that drives the converter. The host can write the staging register alone, write both registers at once, or copy staging into the output.

The block also controls power state. Shutdown can come from a command or from the rising edge of a power-down pin. An allow pin must be high for either to take effect. Shutdown ends on any of three events: a command that updates the output register, a falling edge on the allow pin, or the clear pin. A clear sets both registers to zero or to midscale, selected by a strap input, and returns the user output bit to low. The block also drives a user-settable output bit and a serial readback line that is used for daisy-chaining; a command selects which serial clock edge launches it.

All pins are first synchronised into the system clock domain, and edges are detected there. After each wake-up, a settle flag stays high for a parameterised number of system cycles while the analog reference recovers.

Top module: `sdac_ctrl`

## Requirements
- R1: After reset the output code is 0x800 when `rst_mid` is 1 and 0x000 when it is 0. After reset `out_en` is 1, `upo` is 0, and readback uses the falling-edge mode.
- R2: A frame is 16 bits, most significant bit first: bits 15..13 are the command, bits 12..1 are the code, and bit 0 is filler. Data is sampled on the rising edge of `sclk` only while `cs_n` is low, and the command acts on the rising edge of `cs_n`. Command 001 writes the staging register and leaves `dac_code` unchanged. Command 011 copies staging into `dac_code` and ends shutdown.
- R3: Command 010 writes the code into both registers at once and ends shutdown. This holds for the end codes 0xFFF and 0x000.
- R4: When `cs_n` rises after any count other than 16 rising `sclk` edges (15 and 17 are tested), the frame has no effect on either register.
- R5: Command 101 clears `out_en` only if `sleep_allow` is high. In shutdown, `dac_code` is held and frames still write the staging register. `dout` holds its value while serial traffic continues.
- R6: Command 110 sets `upo` to 1 and command 100 sets it to 0.
- R7: Command 111 with code bit 11 = 1 selects rising-edge readback, and with code bit 11 = 0 selects falling-edge readback. In the falling-edge mode, `dout` during the high phase after the k-th rising edge of a frame equals bit 16-k of the previous frame. In the rising-edge mode it equals bit 15-k.
- R8: A rising edge on `pd_req` clears `out_en` when `sleep_allow` is high and has no effect when `sleep_allow` is low. Returning `pd_req` low does not set `out_en` again.
- R9: A falling edge on `sleep_allow` ends shutdown.
- R10: While `clr_n` is low, both registers take 0x000 (`rst_mid` = 0) or 0x800 (`rst_mid` = 1). Shutdown ends and `upo` goes to 0.
- R11: After every end of shutdown, `ref_settling` is high for exactly SETTLE_CYCLES consecutive system cycles.
- R12: Command 000 changes no register, whatever code it carries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Active-low frame select |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in |
| clr_n | input | 1 | Active-low clear |
| rst_mid | input | 1 | Clear value select: 1 = midscale, 0 = zero |
| pd_req | input | 1 | Power-down request; rising edge enters shutdown |
| sleep_allow | input | 1 | High permits shutdown; a falling edge wakes the block |
| dac_code | output | 12 | Code applied to the converter |
| out_en | output | 1 | High when the analog output is driven (not in shutdown) |
| upo | output | 1 | User-programmable output bit |
| dout | output | 1 | Serial readback and daisy-chain output |
| ref_settling | output | 1 | High while the reference settles after a wake-up |

## Verification
The hardest behaviour to observe is the half-cycle difference between the two readback modes. At the usual sampling point, both modes show the same bit. The bench therefore loads a known frame and then sends a second frame. It samples `dout` late in each high phase of `sclk`, where the rising-edge mode has already advanced and the falling-edge mode has not. The shutdown paths are reached by ordering the pin moves so that the allow pin is low while a request arrives, and then by lowering it from high while the block sleeps. Together these cover a request that the allow pin blocks, a release of the power-down pin that must not wake the block, and a wake caused by the allow pin.

// File: rtl/sdac_pkg.sv
package sdac_pkg;

    localparam int DATA_W = 12;
    localparam int CMD_W  = 3;
    localparam int WORD_W = CMD_W + DATA_W + 1;
    localparam int CNT_W  = $clog2(WORD_W + 2);

    typedef enum logic [CMD_W-1:0] {
        CMD_NOP       = 3'd0,
        CMD_LD_STAGE  = 3'd1,
        CMD_LD_BOTH   = 3'd2,
        CMD_XFER      = 3'd3,
        CMD_UPO_LO    = 3'd4,
        CMD_SLEEP     = 3'd5,
        CMD_UPO_HI    = 3'd6,
        CMD_DOUT_MODE = 3'd7
    } cmd_e;

    // payload of a frame without the trailing filler bit
    typedef struct packed {
        cmd_e              cmd;
        logic [DATA_W-1:0] code;
    } payload_t;

    typedef struct packed {
        logic cs_n;
        logic sclk;
        logic din;
        logic clr_n;
        logic pd;
        logic allow;
    } pins_t;

    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sclk: 1'b0, din: 1'b0,
                                    clr_n: 1'b1, pd: 1'b0, allow: 1'b1};

    function automatic logic [DATA_W-1:0] clear_code(input logic mid);
        logic [DATA_W-1:0] v;
        v = '0;
        v[DATA_W-1] = mid;
        return v;
    endfunction

endpackage

// File: rtl/sdac_sync.sv
module sdac_sync #(
    parameter int            W      = 6,
    parameter int            STAGES = 2,
    parameter logic [W-1:0]  INIT   = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= INIT;
                else     stg[g] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[g] <= INIT;
                else     stg[g] <= stg[g-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/sdac_shift.sv
module sdac_shift
    import sdac_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     cs_low,
    input  logic     cs_rise,
    input  logic     sclk_rise,
    input  logic     sclk_fall,
    input  logic     din_s,
    input  logic     mode_rise,
    input  logic     hold,
    output logic     frame_valid,
    output payload_t payload,
    output logic     dout
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(WORD_W + 1);

    logic [WORD_W-1:0] sr;
    logic [CNT_W-1:0]  count;

    always_ff @(posedge clk) begin
        if (rst) begin
            sr    <= '0;
            count <= '0;
        end else if (!cs_low) begin
            count <= '0;
        end else if (sclk_rise) begin
            sr <= {sr[WORD_W-2:0], din_s};
            if (count != CNT_SAT) count <= count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dout <= 1'b0;
        end else if (cs_low && !hold) begin
            if (mode_rise && sclk_rise)       dout <= sr[WORD_W-2];
            else if (!mode_rise && sclk_fall) dout <= sr[WORD_W-1];
        end
    end

    assign frame_valid = cs_rise && (count == CNT_FULL);
    assign payload     = payload_t'(sr[WORD_W-1:1]);

    AST_DOUT_FROZEN: assert property (@(posedge clk) disable iff (rst)
        hold |=> $stable(dout)); // R5

    AST_FRAME_NEEDS_SELECT: assert property (@(posedge clk) disable iff (rst)
        frame_valid |-> $past(cs_low)); // R4
endmodule

// File: rtl/sdac_regs.sv
module sdac_regs
    import sdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  payload_t          payload,
    input  logic              clr_act,
    input  logic              rst_mid,
    input  logic              allow,
    input  logic              allow_fall,
    input  logic              pd_rise,
    output logic [DATA_W-1:0] dac_code,
    output logic              shut,
    output logic              upo,
    output logic              mode_rise
);
    logic [DATA_W-1:0] stage_q, stage_n, dac_q, dac_n;
    logic              shut_q, shut_n, upo_q, upo_n, mode_q, mode_n;
    logic              sleep_cmd, wake_cmd;

    always_comb begin
        stage_n   = stage_q;
        dac_n     = dac_q;
        upo_n     = upo_q;
        mode_n    = mode_q;
        sleep_cmd = 1'b0;
        wake_cmd  = 1'b0;
        if (frame_valid) begin
            case (payload.cmd)
                CMD_NOP:       ;
                CMD_LD_STAGE:  stage_n = payload.code;
                CMD_LD_BOTH: begin
                    stage_n  = payload.code;
                    dac_n    = payload.code;
                    wake_cmd = 1'b1;
                end
                CMD_XFER: begin
                    dac_n    = stage_q;
                    wake_cmd = 1'b1;
                end
                CMD_UPO_LO:    upo_n = 1'b0;
                CMD_UPO_HI:    upo_n = 1'b1;
                CMD_SLEEP:     sleep_cmd = 1'b1;
                CMD_DOUT_MODE: mode_n = payload.code[DATA_W-1];
            endcase
        end
        shut_n = shut_q;
        if (allow_fall)                          shut_n = 1'b0;
        else if ((sleep_cmd || pd_rise) && allow) shut_n = 1'b1;
        else if (wake_cmd)                       shut_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_q <= clear_code(rst_mid);
            dac_q   <= clear_code(rst_mid);
            shut_q  <= 1'b0;
            upo_q   <= 1'b0;
            mode_q  <= 1'b0;
        end else if (clr_act) begin
            stage_q <= clear_code(rst_mid);
            dac_q   <= clear_code(rst_mid);
            shut_q  <= 1'b0;
            upo_q   <= 1'b0;
        end else begin
            stage_q <= stage_n;
            dac_q   <= dac_n;
            shut_q  <= shut_n;
            upo_q   <= upo_n;
            mode_q  <= mode_n;
        end
    end

    assign dac_code  = dac_q;
    assign shut      = shut_q;
    assign upo       = upo_q;
    assign mode_rise = mode_q;

    AST_SHUT_NEEDS_ALLOW: assert property (@(posedge clk) disable iff (rst)
        $rose(shut_q) |-> $past(allow)); // R5

    AST_CLEAR_RESULT: assert property (@(posedge clk) disable iff (rst)
        clr_act |=> (dac_q == clear_code($past(rst_mid)) && !shut_q && !upo_q)); // R10

    AST_DAC_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!clr_act && !(frame_valid && (payload.cmd == CMD_LD_BOTH || payload.cmd == CMD_XFER)))
        |=> $stable(dac_q)); // R2
endmodule

// File: rtl/sdac_settle.sv
module sdac_settle #(
    parameter int unsigned SETTLE_CYCLES = 200000
) (
    input  logic clk,
    input  logic rst,
    input  logic shut,
    output logic busy
);
    localparam int CW = $clog2(SETTLE_CYCLES + 1);

    logic [CW-1:0] cnt;
    logic          shut_d;
    logic          wake;

    assign wake = shut_d && !shut;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt    <= '0;
            shut_d <= 1'b0;
        end else begin
            shut_d <= shut;
            if (wake)           cnt <= CW'(SETTLE_CYCLES);
            else if (cnt != '0) cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);

    AST_SETTLE_START: assert property (@(posedge clk) disable iff (rst)
        ($past(shut) && !shut) |=> busy); // R11
endmodule

// File: rtl/sdac_ctrl.sv
module sdac_ctrl
    import sdac_pkg::*;
#(
    parameter int unsigned SETTLE_CYCLES = 200000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              din,
    input  logic              clr_n,
    input  logic              rst_mid,
    input  logic              pd_req,
    input  logic              sleep_allow,
    output logic [DATA_W-1:0] dac_code,
    output logic              out_en,
    output logic              upo,
    output logic              dout,
    output logic              ref_settling
);
    pins_t    raw, s;
    logic [3:0] prev;
    logic     cs_rise, sclk_rise, sclk_fall, pd_rise, allow_fall;
    logic     frame_valid, shut, mode_rise;
    payload_t payload;

    assign raw = '{cs_n: cs_n, sclk: sclk, din: din, clr_n: clr_n,
                   pd: pd_req, allow: sleep_allow};

    sdac_sync #(.W($bits(pins_t)), .STAGES(2), .INIT(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (s)
    );

    always_ff @(posedge clk) begin
        if (rst) prev <= {PINS_IDLE.cs_n, PINS_IDLE.sclk, PINS_IDLE.pd, PINS_IDLE.allow};
        else     prev <= {s.cs_n, s.sclk, s.pd, s.allow};
    end

    assign cs_rise    = s.cs_n  && !prev[3];
    assign sclk_rise  = s.sclk  && !prev[2];
    assign sclk_fall  = !s.sclk && prev[2];
    assign pd_rise    = s.pd    && !prev[1];
    assign allow_fall = !s.allow && prev[0];

    sdac_shift u_shift (
        .clk         (clk),
        .rst         (rst),
        .cs_low      (!s.cs_n),
        .cs_rise     (cs_rise),
        .sclk_rise   (sclk_rise),
        .sclk_fall   (sclk_fall),
        .din_s       (s.din),
        .mode_rise   (mode_rise),
        .hold        (shut),
        .frame_valid (frame_valid),
        .payload     (payload),
        .dout        (dout)
    );

    sdac_regs u_regs (
        .clk         (clk),
        .rst         (rst),
        .frame_valid (frame_valid),
        .payload     (payload),
        .clr_act     (!s.clr_n),
        .rst_mid     (rst_mid),
        .allow       (s.allow),
        .allow_fall  (allow_fall),
        .pd_rise     (pd_rise),
        .dac_code    (dac_code),
        .shut        (shut),
        .upo         (upo),
        .mode_rise   (mode_rise)
    );

    sdac_settle #(.SETTLE_CYCLES(SETTLE_CYCLES)) u_settle (
        .clk  (clk),
        .rst  (rst),
        .shut (shut),
        .busy (ref_settling)
    );

    assign out_en = !shut;
endmodule

// File: tb/sdac_ctrl_bench.sv
`timescale 1ns/1ps
module sdac_ctrl_bench;
    localparam int H      = 4;
    localparam int SETTLE = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic cs_n = 1'b1, sclk = 1'b0, din = 1'b0, clr_n = 1'b1;
    logic rst_mid = 1'b1, pd_req = 1'b0, sleep_allow = 1'b1;
    logic [11:0] dac_code;
    logic out_en, upo, dout, ref_settling;

    always #5 clk = ~clk;

    sdac_ctrl #(.SETTLE_CYCLES(SETTLE)) u_sdac_ctrl (
        .clk(clk), .rst(rst), .cs_n(cs_n), .sclk(sclk), .din(din),
        .clr_n(clr_n), .rst_mid(rst_mid), .pd_req(pd_req),
        .sleep_allow(sleep_allow), .dac_code(dac_code), .out_en(out_en),
        .upo(upo), .dout(dout), .ref_settling(ref_settling)
    );

    int  nchk = 0, nfail = 0;
    bit  done = 0;
    bit  run_chk = 0;
    time t_chg = 0;
    logic [11:0] e_stage, e_dac;
    logic        e_shut = 0, e_upo = 0;
    int  pulses = 0, last_len = 0, run_len = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    endtask

    // behavioural model of a command taking effect
    task automatic apply_cmd(input logic [2:0] cmd, input logic [11:0] code);
        case (cmd)
            3'd1: e_stage = code;
            3'd2: begin e_stage = code; e_dac = code; e_shut = 0; end
            3'd3: begin e_dac = e_stage; e_shut = 0; end
            3'd4: e_upo = 0;
            3'd6: e_upo = 1;
            3'd5: if (sleep_allow) e_shut = 1;
            default: ;
        endcase
    endtask

    // kind: 0 none, 1 falling-edge readback, 2 rising-edge readback, 3 held
    task automatic shift_frame(input logic [31:0] w, input int n,
                               input int kind, input logic [15:0] prev_w);
        logic d0;
        d0 = dout;
        @(negedge clk);
        cs_n = 0;
        repeat (H) @(negedge clk);
        for (int k = 1; k <= n; k++) begin
            din = w[n-k];
            repeat (H) @(negedge clk);
            sclk = 1;
            repeat (H) @(negedge clk);
            if (kind == 1) chk("R7 falling-edge readback", dout, prev_w[16-k]);
            if (kind == 2 && k < 16) chk("R7 rising-edge readback", dout, prev_w[15-k]);
            if (kind == 3) chk("R5 dout held in shutdown", dout, d0);
            sclk = 0;
        end
        repeat (H) @(negedge clk);
        cs_n = 1;
        t_chg = $time;
        if (n == 16) apply_cmd(w[15:13], w[12:1]);
        repeat (3 * H) @(negedge clk);
    endtask

    task automatic frame(input logic [2:0] cmd, input logic [11:0] code);
        shift_frame({16'h0, cmd, code, 1'b0}, 16, 0, 16'h0);
    endtask

    task automatic settle_wait(input int n);
        repeat (n) @(negedge clk);
    endtask

    // every-clock comparison with the model once inputs have been quiet
    always @(negedge clk) begin
        if (run_chk && !done && ($time - t_chg) > 100) begin
            chk("R2 dac_code vs model", dac_code, e_dac);
            chk("R5 out_en vs model", out_en, !e_shut);
            chk("R6 upo vs model", upo, e_upo);
        end
    end

    always @(negedge clk) begin
        if (ref_settling) run_len++;
        else if (run_len != 0) begin
            last_len = run_len;
            run_len = 0;
            pulses++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        finish_run();
    end

    initial begin
        int p0;
        repeat (5) @(negedge clk);
        rst = 0;
        settle_wait(10);
        chk("R1 reset code midscale", dac_code, 12'h800);
        chk("R1 reset out_en", out_en, 1);
        chk("R1 reset upo", upo, 0);
        e_stage = 12'h800; e_dac = 12'h800;
        run_chk = 1;

        // R2 staging then transfer
        frame(3'd1, 12'h123);
        chk("R2 stage load leaves dac", dac_code, 12'h800);
        frame(3'd3, 12'h000);
        chk("R2 transfer", dac_code, 12'h123);

        // R3 load both
        frame(3'd2, 12'hABC);
        chk("R3 load both", dac_code, 12'hABC);

        // R4 wrong lengths
        shift_frame({17'h0, 3'd2, 12'h111}, 15, 0, 16'h0);
        chk("R4 15-bit frame ignored", dac_code, 12'hABC);
        shift_frame({15'h0, 3'd1, 12'h222, 2'b00}, 17, 0, 16'h0);
        frame(3'd3, 12'h000);
        chk("R4 17-bit frame did not touch staging", dac_code, 12'hABC);

        // R12 no-op
        frame(3'd0, 12'h555);
        chk("R12 nop keeps dac", dac_code, 12'hABC);
        frame(3'd3, 12'h000);
        chk("R12 nop keeps staging", dac_code, 12'hABC);

        // R6 user output
        frame(3'd6, 12'h000);
        chk("R6 upo high", upo, 1);
        frame(3'd4, 12'h000);
        chk("R6 upo low", upo, 0);

        // R7 readback, falling-edge mode (default after reset, R1)
        frame(3'd0, 12'hA5C);
        shift_frame({16'h0, 3'd0, 12'h3C3, 1'b0}, 16, 1, {3'd0, 12'hA5C, 1'b0});
        // rising-edge mode
        frame(3'd7, 12'h800);
        frame(3'd0, 12'h5A3);
        shift_frame({16'h0, 3'd0, 12'h0F0, 1'b0}, 16, 2, {3'd0, 12'h5A3, 1'b0});
        frame(3'd7, 12'h000);
        frame(3'd0, 12'h9C6);
        shift_frame({16'h0, 3'd0, 12'h333, 1'b0}, 16, 1, {3'd0, 12'h9C6, 1'b0});

        // R5 shutdown by command
        frame(3'd5, 12'h000);
        chk("R5 sleep command", out_en, 0);
        chk("R5 dac held in shutdown", dac_code, 12'hABC);
        frame(3'd1, 12'h456);
        chk("R5 staging write in shutdown keeps dac", dac_code, 12'hABC);
        shift_frame({16'h0, 3'd0, 12'hAAA, 1'b0}, 16, 3, 16'h0);
        p0 = pulses;
        frame(3'd3, 12'h000);
        chk("R5 transfer wakes", out_en, 1);
        chk("R5 staging kept through shutdown", dac_code, 12'h456);
        settle_wait(40);
        chk("R11 settle pulse count", pulses, p0 + 1);
        chk("R11 settle length", last_len, SETTLE);

        // R5/R8 lockout
        @(negedge clk); sleep_allow = 0; t_chg = $time;
        settle_wait(20);
        frame(3'd5, 12'h000);
        chk("R5 sleep blocked by lockout", out_en, 1);
        @(negedge clk); pd_req = 1; t_chg = $time;
        settle_wait(20);
        chk("R8 pd blocked by lockout", out_en, 1);
        @(negedge clk); pd_req = 0; sleep_allow = 1; t_chg = $time;
        settle_wait(20);
        @(negedge clk); pd_req = 1; e_shut = 1; t_chg = $time;
        settle_wait(20);
        chk("R8 pd edge enters shutdown", out_en, 0);
        @(negedge clk); pd_req = 0; t_chg = $time;
        settle_wait(20);
        chk("R8 pd low does not wake", out_en, 0);
        p0 = pulses;
        @(negedge clk); sleep_allow = 0; e_shut = 0; t_chg = $time;
        settle_wait(20);
        chk("R9 allow fall wakes", out_en, 1);
        settle_wait(40);
        chk("R11 settle after allow wake", last_len, SETTLE);
        chk("R11 settle pulse after allow wake", pulses, p0 + 1);
        @(negedge clk); sleep_allow = 1; t_chg = $time;
        settle_wait(20);

        // R10 clear
        frame(3'd6, 12'h000);
        frame(3'd5, 12'h000);
        chk("R5 sleep before clear", out_en, 0);
        @(negedge clk); rst_mid = 0; clr_n = 0;
        e_stage = 12'h000; e_dac = 12'h000; e_shut = 0; e_upo = 0; t_chg = $time;
        settle_wait(20);
        chk("R10 clear to zero", dac_code, 12'h000);
        chk("R10 clear wakes", out_en, 1);
        chk("R10 clear drops upo", upo, 0);
        @(negedge clk); clr_n = 1; t_chg = $time;
        settle_wait(20);
        frame(3'd2, 12'h777);
        @(negedge clk); rst_mid = 1; clr_n = 0;
        e_stage = 12'h800; e_dac = 12'h800; t_chg = $time;
        settle_wait(20);
        @(negedge clk); clr_n = 1; t_chg = $time;
        settle_wait(20);
        chk("R10 clear to midscale", dac_code, 12'h800);
        frame(3'd3, 12'h000);
        chk("R10 staging also cleared", dac_code, 12'h800);

        // R3 end codes
        frame(3'd2, 12'hFFF);
        chk("R3 load both full scale", dac_code, 12'hFFF);
        frame(3'd2, 12'h000);
        chk("R3 load both zero", dac_code, 12'h000);

        settle_wait(20);
        finish_run();
    end
endmodule